// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a 38-bit physical address by fetching two descriptors from a page table held in memory. A requester presents an address and an access kind (read, write or execute) while the walker is idle; the walker latches them together with the 26-bit pointer to the top-level table. It then issues two word reads on a memory read port and examines what comes back. It returns either a physical address or a fault code together with the level that produced the fault.

Every table starts on a 4 KB boundary and holds 1024 four-byte entries. Entry addresses are therefore built by placing fields side by side, with no adder. The top ten bits of the virtual address select the entry in the top-level table. The next ten bits select the entry in the leaf table. The low twelve bits pass unchanged into the physical address. Each memory read uses a valid/ready request and a single response beat, and the response may take any number of cycles to arrive.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `mem_req_valid` is 0 and `res_valid` is 0.
- R2: A request is taken only when `req_ready` is 1, which happens only while idle. `req_vaddr`, `req_access` and `root_ptr` are sampled at acceptance. Later changes to them, and `req_valid` pulses while busy, do not affect the walk in progress.
- R3: The first read address is `{root_ptr, vaddr[31:22], 2'b00}`. It stays constant while `mem_req_valid` is 1 and `mem_req_ready` is 0.
- R4: The second read address is `{L1[31:6], vaddr[21:12], 2'b00}`, where L1 is the first descriptor returned.
- R5: When the walk succeeds, `res_paddr` = `{L2[31:6], vaddr[11:0]}`, `res_fault` = 0 and `res_level` = 1.
- R6: Descriptor bit 0 is present. If it is 0 in the first descriptor, the walk ends with `res_fault` = 1, `res_level` = 0 and `res_paddr` = 0, and no second read is issued.
- R7: If bit 0 of the second descriptor is 0, the result is `res_fault` = 1, `res_level` = 1 and `res_paddr` = 0.
- R8: `req_access` codes are 0 = read, 1 = write, 2 = execute and 3 = reserved. The permission bit checked in the second descriptor is bit 3 for read, bit 4 for write and bit 5 for execute. If that bit is 0, or if the code is 3, the result is `res_fault` = 2, `res_level` = 1 and `res_paddr` = 0. The permission bits of the first descriptor, and bits 1 and 2 (dirty and used) of either descriptor, have no effect.
- R9: `res_valid` is high for exactly one cycle. It rises in the cycle after the deciding response beat, and `req_ready` returns the cycle after that.
- R10: `mem_rsp_valid` is ignored unless the walker is waiting for a response.
- R11: Each memory request is held until it is accepted, and `mem_req_valid` is 0 in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_access | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| root_ptr | input | 26 | Frame number of the top-level table |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 38 | Byte address of the descriptor to read |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | 32 | Descriptor returned by memory |
| res_valid | output | 1 | Result strobe, one cycle |
| res_paddr | output | 38 | Translated address, 0 on a fault |
| res_fault | output | 2 | 0 none, 1 not present, 2 permission |
| res_level | output | 1 | 0 first level, 1 second level |

## Verification
The bench targets these cases:
- An absent top-level entry. A design that ignored it would issue a second read from a garbage base.
- A leaf marked present but missing the needed permission. Checking the wrong bit, or checking the top-level descriptor, gives the wrong fault code.
- All-ones pointer, frame and address fields. These expose any dropped or shifted bit in the concatenations.
- Disturbances during a walk: stalled request acceptance, stray response beats while the walker is not waiting, new request pulses, and a changing root pointer. A design that sampled at the wrong time, or let these through, would report a translation from the wrong table or one cycle off.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W    = 32;
    localparam int PFN_W   = 26;
    localparam int OFF_W   = 12;
    localparam int DESC_W  = 32;
    localparam int ENT_W   = $clog2(DESC_W / 8);
    localparam int IDX_W   = OFF_W - ENT_W;
    localparam int PA_W    = PFN_W + OFF_W;
    localparam int FLAG_W  = DESC_W - PFN_W;

    localparam int F_PRESENT = 0;
    localparam int F_DIRTY   = 1;
    localparam int F_USED    = 2;
    localparam int F_READ    = 3;
    localparam int F_WRITE   = 4;
    localparam int F_EXEC    = 5;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PERM   = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_st_e;

    typedef struct packed {
        walk_st_e            st;
        logic [VA_W-1:0]     va;
        acc_e                acc;
        logic [PFN_W-1:0]    root;
        logic [PFN_W-1:0]    base;
        logic [PA_W-1:0]     pa;
        fault_e              flt;
        logic                lvl;
    } walk_regs_t;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic              sel_leaf,
    input  logic [PFN_W-1:0]  root,
    input  logic [PFN_W-1:0]  base,
    input  logic [VA_W-1:0]   va,
    output logic [PA_W-1:0]   addr
);

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;

    assign dir_idx = va[VA_W-1 -: IDX_W];
    assign tbl_idx = va[OFF_W +: IDX_W];

    // Tables are page aligned, so the entry address is a plain splice.
    always_comb begin
        if (sel_leaf) begin
            addr = {base, tbl_idx, {ENT_W{1'b0}}};
        end else begin
            addr = {root, dir_idx, {ENT_W{1'b0}}};
        end
    end

endmodule

// File: rtl/ptw_desc_check.sv
module ptw_desc_check
    import ptw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  acc_e              acc,
    output logic              present,
    output logic              allowed,
    output logic [PFN_W-1:0]  pfn
);

    logic [FLAG_W-1:0] flags;
    logic              unused_bookkeeping;

    assign flags   = desc[FLAG_W-1:0];
    assign pfn     = desc[DESC_W-1 -: PFN_W];
    assign present = flags[F_PRESENT];

    // Dirty and used bits play no part in translation.
    assign unused_bookkeeping = flags[F_DIRTY] ^ flags[F_USED];

    always_comb begin
        unique case (acc)
            ACC_READ:  allowed = flags[F_READ];
            ACC_WRITE: allowed = flags[F_WRITE];
            ACC_EXEC:  allowed = flags[F_EXEC];
            default:   allowed = 1'b0;
        endcase
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    input  logic [1:0]        req_access,
    input  logic [25:0]       root_ptr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [37:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              res_valid,
    output logic [37:0]       res_paddr,
    output logic [1:0]        res_fault,
    output logic              res_level
);

    walk_regs_t       walk_q, walk_d;
    logic             sel_leaf;
    logic             desc_present;
    logic             desc_allowed;
    logic [PFN_W-1:0] desc_pfn;

    ptw_addr_gen u_addr (
        .sel_leaf (sel_leaf),
        .root     (walk_q.root),
        .base     (walk_q.base),
        .va       (walk_q.va),
        .addr     (mem_req_addr)
    );

    ptw_desc_check u_check (
        .desc    (mem_rsp_data),
        .acc     (walk_q.acc),
        .present (desc_present),
        .allowed (desc_allowed),
        .pfn     (desc_pfn)
    );

    assign sel_leaf = (walk_q.st == ST_L2_REQ);

    always_comb begin
        walk_d        = walk_q;
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;

        unique case (walk_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    walk_d.st   = ST_L1_REQ;
                    walk_d.va   = req_vaddr;
                    walk_d.acc  = acc_e'(req_access);
                    walk_d.root = root_ptr;
                end
            end

            ST_L1_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) begin
                    walk_d.st = ST_L1_WAIT;
                end
            end

            ST_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!desc_present) begin
                        walk_d.st  = ST_DONE;
                        walk_d.flt = FLT_ABSENT;
                        walk_d.lvl = 1'b0;
                        walk_d.pa  = '0;
                    end else begin
                        walk_d.st   = ST_L2_REQ;
                        walk_d.base = desc_pfn;
                    end
                end
            end

            ST_L2_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) begin
                    walk_d.st = ST_L2_WAIT;
                end
            end

            ST_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    walk_d.st  = ST_DONE;
                    walk_d.lvl = 1'b1;
                    if (!desc_present) begin
                        walk_d.flt = FLT_ABSENT;
                        walk_d.pa  = '0;
                    end else if (!desc_allowed) begin
                        walk_d.flt = FLT_PERM;
                        walk_d.pa  = '0;
                    end else begin
                        walk_d.flt = FLT_NONE;
                        walk_d.pa  = {desc_pfn, walk_q.va[OFF_W-1:0]};
                    end
                end
            end

            ST_DONE: begin
                walk_d.st = ST_IDLE;
            end

            default: begin
                walk_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q      <= '0;
            walk_q.st   <= ST_IDLE;
            walk_q.acc  <= ACC_READ;
            walk_q.flt  <= FLT_NONE;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign res_valid = (walk_q.st == ST_DONE);
    assign res_paddr = walk_q.pa;
    assign res_fault = walk_q.flt;
    assign res_level = walk_q.lvl;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic [25:0] root_ptr,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [37:0] mem_req_addr,
    input logic        mem_rsp_valid,
    input logic        res_valid,
    input logic [1:0]  res_fault,
    input logic        res_level
);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !res_valid));

    // R3
    first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req_valid
            && mem_req_addr[37:12] == $past(root_ptr)
            && mem_req_addr[11:2] == $past(req_vaddr[31:22])
            && mem_req_addr[1:0] == 2'b00));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R11
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R9
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && req_ready));

    // R5
    ok_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == 2'd0) |-> res_level);

    // R8
    perm_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == 2'd2) |-> res_level);

    // R10
    stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid && mem_rsp_valid) |=> req_ready);

endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .root_ptr      (root_ptr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .res_valid     (res_valid),
    .res_fault     (res_fault),
    .res_level     (res_level)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic [25:0] root_ptr = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [37:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic [37:0] res_paddr;
    logic [1:0]  res_fault;
    logic        res_level;

    always #2.5 clk = ~clk;

    pt_walker u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_access    (req_access),
        .root_ptr      (root_ptr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .res_valid     (res_valid),
        .res_paddr     (res_paddr),
        .res_fault     (res_fault),
        .res_level     (res_level)
    );

    logic [31:0] mem [logic [37:0]];
    logic [31:0] t_va[$];
    logic [1:0]  t_acc[$];
    logic [25:0] t_root[$];

    int n_cmp = 0;
    int n_bad = 0;

    function automatic logic [31:0] rd(input logic [37:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic map(input logic [25:0] root, input logic [31:0] va,
                       input logic [5:0] f1, input logic [25:0] base,
                       input logic [5:0] f2, input logic [25:0] frame);
        mem[{root, va[31:22], 2'b00}] = {base, f1};
        mem[{base, va[21:12], 2'b00}] = {frame, f2};
    endtask

    task automatic push(input logic [25:0] root, input logic [31:0] va, input logic [1:0] acc);
        t_root.push_back(root);
        t_va.push_back(va);
        t_acc.push_back(acc);
    endtask

    initial begin
        // R8: top-level entry has no permissions; leaf grants read only
        map(26'h0000001, 32'h0040_3ABC, 6'b000001, 26'h0000010, 6'b001001, 26'h2ABCDEF);
        push(26'h0000001, 32'h0040_3ABC, 2'd0);   // R5 read allowed
        push(26'h0000001, 32'h0040_3ABC, 2'd1);   // R8 write denied
        push(26'h0000001, 32'h0040_3ABC, 2'd3);   // R8 reserved code
        map(26'h0000005, 32'h1234_5678, 6'b000111, 26'h0000050, 6'b100111, 26'h0123456);
        push(26'h0000005, 32'h1234_5678, 2'd2);   // R5 execute allowed, dirty/used set
        push(26'h0000005, 32'h1234_5678, 2'd0);   // R8 read denied
        push(26'h0000002, 32'h8000_0123, 2'd0);   // R6 no top-level entry
        mem[{26'h0000003, 10'h155, 2'b00}] = {26'h0000020, 6'b000001};
        push(26'h0000003, 32'h5540_1FFF, 2'd0);   // R7 leaf absent
        map(26'h3FFFFFF, 32'hFFFF_FFFF, 6'b111111, 26'h3FFFFFE, 6'b111111, 26'h3FFFFFF);
        push(26'h3FFFFFF, 32'hFFFF_FFFF, 2'd1);   // R4/R5 all-ones fields
        map(26'h0000004, 32'h0000_0000, 6'b000001, 26'h0000000, 6'b011001, 26'h0000001);
        push(26'h0000004, 32'h0000_0000, 2'd1);   // R4 zero base
        for (int i = 0; i < 48; i++) begin
            logic [25:0] r;
            logic [31:0] v;
            logic [5:0]  f1, f2;
            r  = 26'h100 + 26'(i);
            v  = $urandom;
            f1 = 6'($urandom) | 6'(($urandom % 8) != 0);
            f2 = 6'($urandom) | 6'(($urandom % 8) != 0);
            map(r, v, f1, 26'h8000 + 26'(i), f2, 26'($urandom));
            push(r, v, 2'($urandom));
        end
    end

    // Reference model and stimulus, stepped once per cycle at the falling edge.
    initial begin
        int ph = 0;
        int cyc = 0;
        int gap = 0;
        int pend = -1;
        int done = 0;
        int total;
        logic [31:0] pend_data = '0;
        logic [31:0] m_va = '0;
        logic [1:0]  m_acc = '0;
        logic [25:0] m_root = '0;
        logic [25:0] m_base = '0;
        logic [37:0] m_pa = '0;
        logic [1:0]  m_flt = '0;
        logic        m_lvl = 1'b0;
        bit first = 1'b1;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        total = t_va.size();

        forever begin
            logic        e_ready, e_mv, e_res;
            logic [37:0] e_addr;
            logic        rv, mr, sv;
            logic [31:0] sd, d;
            logic [31:0] nva;
            logic [1:0]  nacc;
            logic [25:0] nroot;
            string tg;

            @(negedge clk);
            cyc++;
            if (cyc > 50000) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R9 watchdog: actual %0d results expected %0d", done, total);
                break;
            end
            if (done == total) break;

            // compare outputs against model
            e_ready = (ph == 0);
            e_mv    = (ph == 1 || ph == 3);
            e_res   = (ph == 5);
            e_addr  = (ph == 1) ? {m_root, m_va[31:22], 2'b00} : {m_base, m_va[21:12], 2'b00};
            chk(req_ready === e_ready, first ? "R1" : "R2", "req_ready", 64'(req_ready), 64'(e_ready));
            chk(mem_req_valid === e_mv, first ? "R1" : "R11", "mem_req_valid", 64'(mem_req_valid), 64'(e_mv));
            chk(res_valid === e_res, first ? "R1" : "R9", "res_valid", 64'(res_valid), 64'(e_res));
            first = 1'b0;
            if (e_mv) begin
                tg = (ph == 1) ? "R3" : "R4";
                chk(mem_req_addr === e_addr, tg, "mem_req_addr", 64'(mem_req_addr), 64'(e_addr));
            end
            if (e_res) begin
                if (m_flt == 2'd0) tg = "R5";
                else if (m_flt == 2'd2) tg = "R8";
                else if (m_lvl) tg = "R7";
                else tg = "R6";
                chk(res_paddr === m_pa, tg, "res_paddr", 64'(res_paddr), 64'(m_pa));
                chk(res_fault === m_flt, tg, "res_fault", 64'(res_fault), 64'(m_flt));
                chk(res_level === m_lvl, tg, "res_level", 64'(res_level), 64'(m_lvl));
            end

            // choose inputs for the coming edge
            rv    = 1'b0;
            nva   = $urandom;
            nacc  = 2'($urandom);
            nroot = 26'($urandom);
            if (ph == 0) begin
                if (gap > 0) begin
                    gap--;
                end else if (t_va.size() > 0) begin
                    rv    = 1'b1;
                    nva   = t_va.pop_front();
                    nacc  = t_acc.pop_front();
                    nroot = t_root.pop_front();
                    gap   = $urandom % 3;
                end
            end else begin
                rv = ($urandom % 2) == 0;   // R2: ignored while busy
            end
            mr = ($urandom % 3) != 0;
            sv = 1'b0;
            sd = $urandom | 32'h1;
            if (pend == 0) begin
                sv   = 1'b1;
                sd   = pend_data;
                pend = -1;
            end else if (pend > 0) begin
                pend--;
            end else if (ph != 2 && ph != 4) begin
                sv = ($urandom % 4) == 0;   // R10: stray beat
            end

            // advance model
            case (ph)
                0: if (rv) begin
                    m_va = nva; m_acc = nacc; m_root = nroot; ph = 1;
                end
                1, 3: if (mr) begin
                    pend      = $urandom % 3;
                    pend_data = rd(e_addr);
                    ph        = ph + 1;
                end
                2: if (sv) begin
                    d = sd;
                    if (!d[0]) begin
                        m_flt = 2'd1; m_lvl = 1'b0; m_pa = '0; ph = 5;
                    end else begin
                        m_base = d[31:6]; ph = 3;
                    end
                end
                4: if (sv) begin
                    bit ok;
                    d = sd;
                    m_lvl = 1'b1;
                    ph = 5;
                    ok = (m_acc == 2'd0) ? d[3] : (m_acc == 2'd1) ? d[4] :
                         (m_acc == 2'd2) ? d[5] : 1'b0;
                    if (!d[0]) begin
                        m_flt = 2'd1; m_pa = '0;
                    end else if (!ok) begin
                        m_flt = 2'd2; m_pa = '0;
                    end else begin
                        m_flt = 2'd0; m_pa = {d[31:6], m_va[11:0]};
                    end
                end
                5: begin
                    ph = 0;
                    done++;
                end
                default: ph = 0;
            endcase

            req_valid     = rv;
            req_vaddr     = nva;
            req_access    = nacc;
            root_ptr      = nroot;
            mem_req_ready = mr;
            mem_rsp_valid = sv;
            mem_rsp_data  = sd;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule